// File: doc/BRIEF.md
# Indirect Target Predictor Training Controller

This block turns one resolved indirect jump into the table writes of a tagged, history-indexed target predictor. For each update it takes the providing entry (the longest-history table that matched, if any), that entry's confidence counter, useful bit and stored target, and the target offered by the alternate prediction. It also takes the jump's actual target and the useful bits of the entries that the update indexes in every table. From these it computes the provider's new counter, target and useful bit, and it picks at most one longer-history table in which a fresh entry is to be written.

The choice among allocation candidates is spread across tables by a 64-bit linear feedback shift register, which masks candidates pseudo-randomly. A saturating tick counter weighs failed allocations against successful ones. When failures dominate long enough, the block raises a one-cycle request to clear every useful bit in all tables. Table storage, indexing and write ordering live outside this block. The block only produces the values to be written, one cycle after each update.

Top module: `tgt_train_ctrl`

## Requirements
- R1: While rst_n is low, and after it until the first update, res_valid, res_prov_wr, res_alloc_valid and res_useful_clear are 0.
- R2: The new provider counter is the old counter plus 1 when the provider target equals the actual target, and minus 1 otherwise. It saturates at 0 and at 2**CTR_W-1 (3 by default).
- R3: The new provider target is the actual target when the old counter is 0. Otherwise it is the old provider target.
- R4: The new provider useful bit is 1 when the provider target equals the actual target and the alternate target differs from the provider target. Otherwise it is the old useful bit.
- R5: Table i is an allocation candidate when its indexed useful bit (upd_useful_vec bit i) is 0 and either no provider hit or i is greater than upd_prov_idx. When the provider is table NUM_TABLES-1, or no candidate exists, res_alloc_valid is 0 and res_alloc_sel is 0.
- R6: The chosen table is the lowest-numbered candidate i whose random mask bit (LFSR bit i) is 1. If the mask removes every candidate, the lowest-numbered candidate is chosen. res_alloc_sel is one-hot with bit i meaning table i.
- R7: A 8-bit tick count (TICK_W) starts at 0. It adds 1 for each failed allocation attempt and subtracts 1, floored at 0, for each successful one. When a failure brings it to 2**TICK_W-1, res_useful_clear is 1 with that update's result and the count returns to 0.
- R8: The random source is a 64-bit register loaded with LFSR_SEED (nonzero) at reset. On each update it shifts left by one, with new bit 0 equal to the XOR of bits 63, 62, 60 and 59. The mask of an update uses the value before that update's shift.
- R9: All results appear in the clock cycle after upd_valid with res_valid=1, and res_prov_wr equals upd_prov_hit of that update. Without an update, res_valid, res_alloc_valid and res_useful_clear are 0.
- R10: res_alloc_tgt equals the actual target of the update. A new entry is written with counter 0 and useful 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| upd_valid | input | 1 | One resolved indirect jump is presented |
| upd_prov_hit | input | 1 | Some tagged table provided the prediction |
| upd_prov_idx | input | TID_W | Providing table number, 0 = shortest history |
| upd_prov_ctr | input | CTR_W | Provider confidence counter before update |
| upd_prov_useful | input | 1 | Provider useful bit before update |
| upd_prov_tgt | input | TGT_W | Target stored in the provider entry |
| upd_alt_tgt | input | TGT_W | Target of the alternate prediction |
| upd_actual_tgt | input | TGT_W | Resolved jump target |
| upd_useful_vec | input | NUM_TABLES | Useful bit of the indexed entry in each table |
| res_valid | output | 1 | Results below belong to last cycle's update |
| res_prov_wr | output | 1 | Write the provider entry |
| res_prov_ctr | output | CTR_W | New provider counter |
| res_prov_tgt | output | TGT_W | New provider target |
| res_prov_useful | output | 1 | New provider useful bit |
| res_alloc_valid | output | 1 | An entry is allocated |
| res_alloc_sel | output | NUM_TABLES | One-hot table chosen for allocation |
| res_alloc_tgt | output | TGT_W | Target of the allocated entry |
| res_useful_clear | output | 1 | Clear all useful bits in all tables |

## Verification
Every result of an update, including the allocation choice and the useful-clear pulse, is due exactly one clock edge after the edge that samples upd_valid. The bench drives an update just after a rising edge and computes its expected results at once from its own model of the counter, random register and tick count. It moves them into the current-cycle slot at the next rising edge and compares the outputs at the following falling edge. In cycles without an update, that slot holds an idle expectation, so stray valid, allocation or clear outputs are caught in the same way.

// File: rtl/tgt_train_pkg.sv
package tgt_train_pkg;
  localparam int RND_W = 64;

  // Saturating up/down step of a small confidence counter.
  function automatic logic [7:0] sat_step(input logic [7:0] val, input logic up,
                                          input logic [7:0] top);
    logic [7:0] r;
    if (up) r = (val == top) ? val : val + 8'd1;
    else    r = (val == 8'd0) ? val : val - 8'd1;
    return r;
  endfunction
endpackage

// File: rtl/tgt_prov_upd.sv
module tgt_prov_upd #(
  parameter int CTR_W = 2,
  parameter int TGT_W = 39
) (
  input  logic [CTR_W-1:0] ctr,
  input  logic             useful,
  input  logic [TGT_W-1:0] prov_tgt,
  input  logic [TGT_W-1:0] alt_tgt,
  input  logic [TGT_W-1:0] act_tgt,
  output logic [CTR_W-1:0] ctr_nxt,
  output logic [TGT_W-1:0] tgt_nxt,
  output logic             useful_nxt
);
  import tgt_train_pkg::*;
  localparam logic [7:0] CTR_TOP = 8'((1 << CTR_W) - 1);

  logic       hit_ok;
  logic [7:0] ctr_wide;

  always_comb begin
    hit_ok     = (prov_tgt == act_tgt);
    ctr_wide   = sat_step(8'(ctr), hit_ok, CTR_TOP);
    ctr_nxt    = ctr_wide[CTR_W-1:0];
    tgt_nxt    = (ctr == '0) ? act_tgt : prov_tgt;
    useful_nxt = useful | (hit_ok & (alt_tgt != prov_tgt));
  end
endmodule

// File: rtl/tgt_alloc_pick.sv
module tgt_alloc_pick #(
  parameter int NUM_TABLES = 5,
  parameter int TID_W      = 3
) (
  input  logic                  prov_hit,
  input  logic [TID_W-1:0]      prov_idx,
  input  logic [NUM_TABLES-1:0] useful_vec,
  input  logic [NUM_TABLES-1:0] rnd_mask,
  output logic                  ok,
  output logic [NUM_TABLES-1:0] sel
);
  logic [NUM_TABLES-1:0] longer;
  logic [NUM_TABLES-1:0] cand;
  logic [NUM_TABLES-1:0] pool;

  for (genvar g = 0; g < NUM_TABLES; g++) begin : g_longer
    assign longer[g] = !prov_hit || (g > int'(prov_idx));
  end

  always_comb begin
    cand = longer & ~useful_vec;
    pool = ((cand & rnd_mask) != '0) ? (cand & rnd_mask) : cand;
    ok   = (cand != '0);
    sel  = '0;
    for (int i = NUM_TABLES - 1; i >= 0; i--) begin
      if (pool[i]) begin
        sel    = '0;
        sel[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tgt_rnd_lfsr.sv
module tgt_rnd_lfsr #(
  parameter int                         OUT_W = 5,
  parameter logic [tgt_train_pkg::RND_W-1:0] SEED = 64'h1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [OUT_W-1:0] mask
);
  import tgt_train_pkg::*;
  logic [RND_W-1:0] state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (adv)
      state_d = {state_q[RND_W-2:0],
                 state_q[63] ^ state_q[62] ^ state_q[60] ^ state_q[59]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  assign mask = state_q[OUT_W-1:0];
endmodule

// File: rtl/tgt_tick_ctr.sv
module tgt_tick_ctr #(
  parameter int TICK_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fail,
  input  logic succ,
  output logic clr
);
  localparam logic [TICK_W-1:0] TICK_TOP = '1;
  logic [TICK_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    clr   = 1'b0;
    if (fail) begin
      if (cnt_q + 1'b1 == TICK_TOP) begin
        clr   = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (succ && cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tgt_train_ctrl.sv
module tgt_train_ctrl #(
  parameter int          NUM_TABLES = 5,
  parameter int          CTR_W      = 2,
  parameter int          TGT_W      = 39,
  parameter int          TICK_W     = 8,
  parameter logic [63:0] LFSR_SEED  = 64'h0000_0000_0000_0001,
  localparam int         TID_W      = (NUM_TABLES > 1) ? $clog2(NUM_TABLES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  upd_valid,
  input  logic                  upd_prov_hit,
  input  logic [TID_W-1:0]      upd_prov_idx,
  input  logic [CTR_W-1:0]      upd_prov_ctr,
  input  logic                  upd_prov_useful,
  input  logic [TGT_W-1:0]      upd_prov_tgt,
  input  logic [TGT_W-1:0]      upd_alt_tgt,
  input  logic [TGT_W-1:0]      upd_actual_tgt,
  input  logic [NUM_TABLES-1:0] upd_useful_vec,
  output logic                  res_valid,
  output logic                  res_prov_wr,
  output logic [CTR_W-1:0]      res_prov_ctr,
  output logic [TGT_W-1:0]      res_prov_tgt,
  output logic                  res_prov_useful,
  output logic                  res_alloc_valid,
  output logic [NUM_TABLES-1:0] res_alloc_sel,
  output logic [TGT_W-1:0]      res_alloc_tgt,
  output logic                  res_useful_clear
);
  logic [CTR_W-1:0]      ctr_nxt;
  logic [TGT_W-1:0]      tgt_nxt;
  logic                  useful_nxt;
  logic [NUM_TABLES-1:0] rnd_mask;
  logic                  alloc_ok;
  logic [NUM_TABLES-1:0] alloc_sel;
  logic                  attempt;
  logic                  tick_clr;

  tgt_prov_upd #(.CTR_W(CTR_W), .TGT_W(TGT_W)) prov_i (
    .ctr(upd_prov_ctr), .useful(upd_prov_useful), .prov_tgt(upd_prov_tgt),
    .alt_tgt(upd_alt_tgt), .act_tgt(upd_actual_tgt),
    .ctr_nxt(ctr_nxt), .tgt_nxt(tgt_nxt), .useful_nxt(useful_nxt)
  );

  tgt_rnd_lfsr #(.OUT_W(NUM_TABLES), .SEED(LFSR_SEED)) rnd_i (
    .clk(clk), .rst_n(rst_n), .adv(upd_valid), .mask(rnd_mask)
  );

  tgt_alloc_pick #(.NUM_TABLES(NUM_TABLES), .TID_W(TID_W)) pick_i (
    .prov_hit(upd_prov_hit), .prov_idx(upd_prov_idx), .useful_vec(upd_useful_vec),
    .rnd_mask(rnd_mask), .ok(alloc_ok), .sel(alloc_sel)
  );

  // An attempt is made unless the provider already has the longest history.
  assign attempt = upd_valid &&
                   (!upd_prov_hit || int'(upd_prov_idx) < NUM_TABLES - 1);

  tgt_tick_ctr #(.TICK_W(TICK_W)) tick_i (
    .clk(clk), .rst_n(rst_n),
    .fail(attempt && !alloc_ok), .succ(attempt && alloc_ok), .clr(tick_clr)
  );

  // Qualifier flags: registered every cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid        <= 1'b0;
      res_prov_wr      <= 1'b0;
      res_alloc_valid  <= 1'b0;
      res_useful_clear <= 1'b0;
    end else begin
      res_valid        <= upd_valid;
      res_prov_wr      <= upd_valid && upd_prov_hit;
      res_alloc_valid  <= attempt && alloc_ok;
      res_useful_clear <= tick_clr;
    end
  end

  // Data fields: loaded only on an update.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_prov_ctr    <= '0;
      res_prov_tgt    <= '0;
      res_prov_useful <= 1'b0;
      res_alloc_sel   <= '0;
      res_alloc_tgt   <= '0;
    end else if (upd_valid) begin
      res_prov_ctr    <= ctr_nxt;
      res_prov_tgt    <= tgt_nxt;
      res_prov_useful <= useful_nxt;
      res_alloc_sel   <= attempt ? alloc_sel : '0;
      res_alloc_tgt   <= upd_actual_tgt;
    end
  end
endmodule

// File: rtl/tgt_train_ctrl_chk.sv
module tgt_train_ctrl_chk #(
  parameter int NUM_TABLES = 5,
  parameter int CTR_W      = 2,
  parameter int TGT_W      = 39,
  parameter int TID_W      = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  upd_valid,
  input logic                  upd_prov_hit,
  input logic [TID_W-1:0]      upd_prov_idx,
  input logic [CTR_W-1:0]      upd_prov_ctr,
  input logic [TGT_W-1:0]      upd_prov_tgt,
  input logic [TGT_W-1:0]      upd_actual_tgt,
  input logic [NUM_TABLES-1:0] upd_useful_vec,
  input logic                  res_valid,
  input logic [CTR_W-1:0]      res_prov_ctr,
  input logic [TGT_W-1:0]      res_prov_tgt,
  input logic                  res_alloc_valid,
  input logic [NUM_TABLES-1:0] res_alloc_sel,
  input logic                  res_useful_clear
);
  localparam logic [CTR_W-1:0] CMAX = '1;

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> res_valid);
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> (!res_valid && !res_alloc_valid && !res_useful_clear));
  assert_ctr_saturate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_prov_ctr == CMAX && upd_prov_tgt == upd_actual_tgt)
      |=> res_prov_ctr == CMAX);
  assert_tgt_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_prov_ctr != '0) |=> res_prov_tgt == $past(upd_prov_tgt));
  assert_alloc_not_useful_R5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> (res_alloc_sel & $past(upd_useful_vec)) == '0);
  assert_longest_no_alloc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_prov_hit && int'(upd_prov_idx) == NUM_TABLES - 1)
      |=> !res_alloc_valid);
  assert_alloc_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($onehot0(res_alloc_sel) && (res_alloc_valid == (res_alloc_sel != '0))));
  assert_clear_on_fail_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_useful_clear |-> (res_valid && !res_alloc_valid));
endmodule

bind tgt_train_ctrl tgt_train_ctrl_chk #(
  .NUM_TABLES(NUM_TABLES), .CTR_W(CTR_W), .TGT_W(TGT_W), .TID_W(TID_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_prov_hit(upd_prov_hit),
  .upd_prov_idx(upd_prov_idx), .upd_prov_ctr(upd_prov_ctr),
  .upd_prov_tgt(upd_prov_tgt), .upd_actual_tgt(upd_actual_tgt),
  .upd_useful_vec(upd_useful_vec), .res_valid(res_valid),
  .res_prov_ctr(res_prov_ctr), .res_prov_tgt(res_prov_tgt),
  .res_alloc_valid(res_alloc_valid), .res_alloc_sel(res_alloc_sel),
  .res_useful_clear(res_useful_clear)
);

// File: tb/tgt_train_ctrl_tb_top.sv
`timescale 1ns/1ps
module tgt_train_ctrl_tb_top;
  localparam int NT = 5;
  localparam int CW = 2;
  localparam int TW = 39;
  localparam int IW = 3;
  localparam logic [63:0] SEED = 64'h0000_0000_0000_0001;

  typedef struct packed {
    logic          valid;
    logic          wr;
    logic [CW-1:0] ctr;
    logic [TW-1:0] tgt;
    logic          useful;
    logic          aval;
    logic [NT-1:0] asel;
    logic [TW-1:0] atgt;
    logic          clr;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic          upd_valid;
  logic          upd_prov_hit;
  logic [IW-1:0] upd_prov_idx;
  logic [CW-1:0] upd_prov_ctr;
  logic          upd_prov_useful;
  logic [TW-1:0] upd_prov_tgt, upd_alt_tgt, upd_actual_tgt;
  logic [NT-1:0] upd_useful_vec;
  logic          res_valid, res_prov_wr, res_prov_useful, res_alloc_valid, res_useful_clear;
  logic [CW-1:0] res_prov_ctr;
  logic [TW-1:0] res_prov_tgt, res_alloc_tgt;
  logic [NT-1:0] res_alloc_sel;

  int   n_chk = 0;
  int   n_bad = 0;
  int   cyc   = 0;
  bit   done  = 0;
  exp_t pend, cur;
  logic [63:0] m_rnd;
  int   m_tick;
  int   n_clr_seen = 0;

  always #5 clk = ~clk;

  tgt_train_ctrl #(.NUM_TABLES(NT), .CTR_W(CW), .TGT_W(TW), .LFSR_SEED(SEED)) dut_i (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_prov_hit(upd_prov_hit),
    .upd_prov_idx(upd_prov_idx), .upd_prov_ctr(upd_prov_ctr),
    .upd_prov_useful(upd_prov_useful), .upd_prov_tgt(upd_prov_tgt),
    .upd_alt_tgt(upd_alt_tgt), .upd_actual_tgt(upd_actual_tgt),
    .upd_useful_vec(upd_useful_vec), .res_valid(res_valid), .res_prov_wr(res_prov_wr),
    .res_prov_ctr(res_prov_ctr), .res_prov_tgt(res_prov_tgt),
    .res_prov_useful(res_prov_useful), .res_alloc_valid(res_alloc_valid),
    .res_alloc_sel(res_alloc_sel), .res_alloc_tgt(res_alloc_tgt),
    .res_useful_clear(res_useful_clear)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // Behavioural model of one update: returns what is due a cycle later.
  function automatic exp_t model(input logic hit, input int idx, input int ctr,
                                 input logic use_b, input logic [TW-1:0] pt,
                                 input logic [TW-1:0] at, input logic [TW-1:0] act,
                                 input logic [NT-1:0] uv);
    exp_t e;
    int cand[$];
    int pick;
    bit tried;
    e = '0;
    e.valid = 1'b1;
    e.wr    = hit;
    if (pt == act) e.ctr = CW'((ctr == 3) ? 3 : ctr + 1);
    else           e.ctr = CW'((ctr == 0) ? 0 : ctr - 1);
    e.tgt    = (ctr == 0) ? act : pt;
    e.useful = use_b || ((pt == act) && (at != pt));
    e.atgt   = act;
    tried    = !hit || (idx < NT - 1);
    if (tried) begin
      for (int i = 0; i < NT; i++)
        if ((!hit || i > idx) && !uv[i]) cand.push_back(i);
      pick = -1;
      foreach (cand[k]) if (pick < 0 && m_rnd[cand[k]]) pick = cand[k];
      if (pick < 0 && cand.size() > 0) pick = cand[0];
      if (pick >= 0) begin
        e.aval = 1'b1;
        e.asel[pick] = 1'b1;
        if (m_tick > 0) m_tick--;
      end else begin
        m_tick++;
        if (m_tick == 255) begin
          e.clr  = 1'b1;
          m_tick = 0;
        end
      end
    end
    m_rnd = {m_rnd[62:0], m_rnd[63] ^ m_rnd[62] ^ m_rnd[60] ^ m_rnd[59]};
    return e;
  endfunction

  task automatic idle();
    @(posedge clk); #2;
    upd_valid = 1'b0;
    pend = '0;
  endtask

  task automatic upd(input logic hit, input int idx, input int ctr, input logic use_b,
                     input logic [TW-1:0] pt, input logic [TW-1:0] at,
                     input logic [TW-1:0] act, input logic [NT-1:0] uv);
    @(posedge clk); #2;
    upd_valid = 1'b1; upd_prov_hit = hit; upd_prov_idx = IW'(idx);
    upd_prov_ctr = CW'(ctr); upd_prov_useful = use_b; upd_prov_tgt = pt;
    upd_alt_tgt = at; upd_actual_tgt = act; upd_useful_vec = uv;
    pend = model(hit, idx, ctr, use_b, pt, at, act, uv);
  endtask

  // Expected values move into the current-cycle slot at each edge.
  always @(posedge clk) begin
    cyc++;
    cur = pend;
    if (cyc > 150000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R1 valid in reset", 64'(res_valid), 0);
      chk("R1 alloc in reset", 64'(res_alloc_valid), 0);
      chk("R1 clear in reset", 64'(res_useful_clear), 0);
      chk("R1 wr in reset", 64'(res_prov_wr), 0);
    end else if (cur.valid) begin
      chk("R9 valid", 64'(res_valid), 1);
      chk("R9 prov_wr", 64'(res_prov_wr), 64'(cur.wr));
      chk("R2 ctr", 64'(res_prov_ctr), 64'(cur.ctr));
      chk("R3 target", 64'(res_prov_tgt), 64'(cur.tgt));
      chk("R4 useful", 64'(res_prov_useful), 64'(cur.useful));
      chk("R5 alloc_valid", 64'(res_alloc_valid), 64'(cur.aval));
      chk("R6 alloc_sel", 64'(res_alloc_sel), 64'(cur.asel));
      chk("R10 alloc_tgt", 64'(res_alloc_tgt), 64'(cur.atgt));
      chk("R7 useful_clear", 64'(res_useful_clear), 64'(cur.clr));
      if (res_useful_clear) n_clr_seen++;
    end else begin
      chk("R9 idle valid", 64'(res_valid), 0);
      chk("R9 idle alloc", 64'(res_alloc_valid), 0);
      chk("R9 idle clear", 64'(res_useful_clear), 0);
    end
  end

  initial begin
    pend = '0; cur = '0; m_rnd = SEED; m_tick = 0;
    rst_n = 1'b0; upd_valid = 1'b0; upd_prov_hit = 1'b0; upd_prov_idx = '0;
    upd_prov_ctr = '0; upd_prov_useful = 1'b0; upd_prov_tgt = '0;
    upd_alt_tgt = '0; upd_actual_tgt = '0; upd_useful_vec = '0;
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    idle(); idle();
    // R2 saturation at top, R4 set, R5/R6 pick among 2..4, R8 seed mask used first
    upd(1, 1, 3, 0, 39'h100, 39'h200, 39'h100, 5'b00000);
    // R2 floor, R3 replace on ctr 0
    upd(1, 2, 0, 0, 39'h111, 39'h111, 39'h222, 5'b00000);
    // R3 keep on ctr 2, counter down
    upd(1, 0, 2, 1, 39'h333, 39'h444, 39'h555, 5'b10101);
    // R5 longest provider: no attempt
    upd(1, 4, 1, 0, 39'h7, 39'h8, 39'h7, 5'b00000);
    // R5 no provider: all tables candidates
    upd(0, 0, 0, 0, 39'h1, 39'h2, 39'h3, 5'b00011);
    // R4 correct but alternate agrees: useful kept 0
    upd(1, 3, 1, 0, 39'h9, 39'h9, 39'h9, 5'b00000);
    // R5 every candidate useful: failure
    upd(1, 0, 1, 0, 39'h9, 39'h9, 39'h9, 5'b11110);
    idle();
    // R7 enough failures to reach saturation and trigger the clear
    for (int i = 0; i < 300; i++) begin
      upd(1, 2, 1, 0, 39'h5, 39'h6, 39'h5, 5'b11000);
      if (i % 37 == 0) idle();
    end
    // Mixed traffic: R2..R10
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 3) == 0) idle();
      else upd(1'($urandom_range(0, 4) != 0), $urandom_range(0, NT - 1),
               $urandom_range(0, 3), 1'($urandom_range(0, 1)),
               TW'($urandom_range(0, 3)), TW'($urandom_range(0, 3)),
               TW'($urandom_range(0, 3)),
               NT'($urandom_range(0, 31) | ($urandom_range(0, 1) ? 31 : 0)));
    end
    idle(); idle();
    chk("R7 clear pulses seen", 64'(n_clr_seen > 0), 1);
    done = 1;
    finish_run();
  end
endmodule